// File: doc/BRIEF.md
# Multi-mode operand address unit

This unit fetches one source operand for a small register-machine datapath. Each request carries a 4-bit mode code, two register numbers (base and index), a 32-bit constant field and a 2-bit element-size code that selects d = 1, 2, 4 or 8 bytes. The unit reads the register file through two combinational read ports. It reads a single-port synchronous data memory that returns data one cycle after the address. It computes the effective address, issues the read and returns the operand with a one-cycle valid pulse. For the two stepping modes it also returns a base-register write-back.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops for exactly one cycle after a memory-indirect request is taken, because the memory port then carries the second read. In every other case the unit takes a request on every cycle. The result side has no back-pressure: `op_valid`, `ill_mode` and `upd_en` are single-cycle pulses that the datapath must consume when they appear. The constant field, base-register and index-register values are treated as unsigned 32-bit quantities. All address sums wrap modulo 2^32.

Top module: `opnd_addr_unit`

## Requirements
- R1: Mode 0 (register) returns the base register's value and drives no memory read in the cycle the request is taken.
- R2: Mode 1 (immediate) returns the constant field unchanged.
- R3: Mode 2 (displacement) returns memory at base register + constant; mode 3 (register-indirect) returns memory at the base register value.
- R4: Mode 4 (indexed) returns memory at base register + index register.
- R5: Mode 5 (absolute) returns memory at the constant field used as the address.
- R6: Mode 6 (memory-indirect) reads memory at the base register to obtain a pointer, then reads memory at that pointer; the operand appears two cycles after the request is taken, and `req_ready` is low in the cycle between.
- R7: Mode 7 (post-increment) reads memory at the unmodified base value and raises `upd_en` with `upd_reg` = base number and `upd_val` = base + d.
- R8: Mode 8 (pre-decrement) reads memory at base − d and raises `upd_en` with `upd_reg` = base number and `upd_val` = base − d.
- R9: Mode 9 (scaled) returns memory at constant + base + index × d, where element-size codes 0, 1, 2, 3 give d = 1, 2, 4, 8.
- R10: Mode codes 10 to 15 raise `ill_mode` for one cycle, one cycle after the request is taken, with no `op_valid`, no `upd_en` and no memory read.
- R11: For every mode except memory-indirect, `op_valid` (or `ill_mode`) appears exactly one cycle after the request is taken, and back-to-back requests are taken on consecutive cycles.
- R12: `upd_en` is raised only in a cycle where `op_valid` is high, and only for modes 7 and 8.
- R13: All address and update arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_mode | input | 4 | Addressing mode code |
| req_ra | input | 4 | Base register number |
| req_rb | input | 4 | Index register number |
| req_const | input | 32 | Constant / displacement / absolute address field |
| req_esz | input | 2 | Element-size code, d = 1 << code |
| rf_a_addr | output | 4 | Register-file read port A number (base) |
| rf_a_data | input | 32 | Register-file read port A data |
| rf_b_addr | output | 4 | Register-file read port B number (index) |
| rf_b_data | input | 32 | Register-file read port B data |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |
| op_valid | output | 1 | Operand valid pulse |
| op_data | output | 32 | Operand value |
| ill_mode | output | 1 | Illegal mode code pulse |
| upd_en | output | 1 | Base-register write-back enable |
| upd_reg | output | 4 | Write-back register number |
| upd_val | output | 32 | Write-back value |

## Verification
On every cycle the assertions check several rules. A register, immediate or illegal request never strobes memory. An accepted request is answered on the next cycle, or on the one after it for memory-indirect. The ready signal drops after a pointer fetch. A write-back never appears without a valid operand, and a valid operand and an illegal-mode flag never appear together. Only the bench's scenarios can show that each mode's effective address and operand value are right. This includes the element-size scaling for all four codes, the wrap of sums past 2^32 and the write-back values for post-increment and pre-decrement.

// File: rtl/oau_pkg.sv
package oau_pkg;
  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_IMM  = 4'd1,
    M_DISP = 4'd2,
    M_RIND = 4'd3,
    M_IDX  = 4'd4,
    M_ABS  = 4'd5,
    M_MIND = 4'd6,
    M_PINC = 4'd7,
    M_PDEC = 4'd8,
    M_SCL  = 4'd9
  } mode_e;

  // What the first stage resolved the request into
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_VAL  = 3'd1,   // operand is a value, no memory
    K_MEM  = 3'd2,   // single memory read
    K_PTR  = 3'd3,   // pointer fetch, second read follows
    K_ILL  = 3'd4    // unknown mode code
  } kind_e;
endpackage

// File: rtl/oau_agu.sv
module oau_agu
  import oau_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SZW = 2
) (
  input  logic [3:0]     mode,
  input  logic [DW-1:0]  base,
  input  logic [DW-1:0]  idx,
  input  logic [DW-1:0]  konst,
  input  logic [SZW-1:0] esz,
  output kind_e          kind,
  output logic [DW-1:0]  addr,
  output logic [DW-1:0]  val,
  output logic           upd_en,
  output logic [DW-1:0]  upd_val
);
  logic [DW-1:0] step, scaled, stepped_down;

  // d and index*d both come from a shift; sums wrap at DW bits
  assign step         = DW'(1) << esz;
  assign scaled       = idx << esz;
  assign stepped_down = base - step;

  always_comb begin
    kind    = K_MEM;
    addr    = base;
    val     = base;
    upd_en  = 1'b0;
    upd_val = base;
    case (mode)
      M_REG:  kind = K_VAL;
      M_IMM:  begin kind = K_VAL; val = konst; end
      M_DISP: addr = base + konst;
      M_RIND: addr = base;
      M_IDX:  addr = base + idx;
      M_ABS:  addr = konst;
      M_MIND: kind = K_PTR;
      M_PINC: begin upd_en = 1'b1; upd_val = base + step; end
      M_PDEC: begin addr = stepped_down; upd_en = 1'b1; upd_val = stepped_down; end
      M_SCL:  addr = konst + base + scaled;
      default: kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  kind_e         kind_in,
  input  logic [DW-1:0] val_in,
  input  logic          upd_en_in,
  input  logic [RW-1:0] upd_reg_in,
  input  logic [DW-1:0] upd_val_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          ptr_phase,
  output logic          ready,
  output logic          op_valid,
  output logic [DW-1:0] op_data,
  output logic          ill,
  output logic          upd_en,
  output logic [RW-1:0] upd_reg,
  output logic [DW-1:0] upd_val
);
  logic          s1_vld, s2_vld, s1_upd;
  kind_e         s1_kind;
  logic [DW-1:0] s1_val, s1_uval;
  logic [RW-1:0] s1_ureg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      s1_kind <= K_NONE;
      s1_upd  <= 1'b0;
      s1_val  <= '0;
      s1_uval <= '0;
      s1_ureg <= '0;
    end else begin
      s1_vld <= take;
      s2_vld <= ptr_phase;
      if (take) begin
        s1_kind <= kind_in;
        s1_val  <= val_in;
        s1_upd  <= upd_en_in && (kind_in == K_MEM);
        s1_uval <= upd_val_in;
        s1_ureg <= upd_reg_in;
      end
    end
  end

  assign ptr_phase = s1_vld && (s1_kind == K_PTR);
  assign ready     = !ptr_phase;
  assign op_valid  = (s1_vld && (s1_kind == K_VAL || s1_kind == K_MEM)) || s2_vld;
  assign op_data   = (s1_vld && s1_kind == K_VAL) ? s1_val : mem_rdata;
  assign ill       = s1_vld && (s1_kind == K_ILL);
  assign upd_en    = s1_vld && s1_upd;
  assign upd_reg   = s1_ureg;
  assign upd_val   = s1_uval;

  // R6: after a pointer fetch is taken, the next cycle refuses requests
  a_r6_busy_after_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind_in == K_PTR) |=> !ready);
  // R6: the pointer cycle is followed by the operand
  a_r6_second_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_phase |=> op_valid);
  // R11: single-step kinds answer on the next cycle
  a_r11_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (kind_in == K_VAL || kind_in == K_MEM)) |=> op_valid);
  // R10: illegal codes flag one cycle later
  a_r10_ill_next: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind_in == K_ILL) |=> (ill && !op_valid && !upd_en));
  // R12: write-back only with an operand
  a_r12_upd_with_op: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> op_valid);
  // R10: flag and operand are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ill && op_valid));
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RW  = 4,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_mode,
  input  logic [RW-1:0]  req_ra,
  input  logic [RW-1:0]  req_rb,
  input  logic [DW-1:0]  req_const,
  input  logic [SZW-1:0] req_esz,
  output logic [RW-1:0]  rf_a_addr,
  input  logic [DW-1:0]  rf_a_data,
  output logic [RW-1:0]  rf_b_addr,
  input  logic [DW-1:0]  rf_b_data,
  output logic           mem_en,
  output logic [DW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           op_valid,
  output logic [DW-1:0]  op_data,
  output logic           ill_mode,
  output logic           upd_en,
  output logic [RW-1:0]  upd_reg,
  output logic [DW-1:0]  upd_val
);
  kind_e         kind;
  logic [DW-1:0] ea, imm_val, wb_val;
  logic          wb_en, take, ptr_phase;

  assign rf_a_addr = req_ra;
  assign rf_b_addr = req_rb;
  assign take      = req_valid && req_ready;

  oau_agu #(.DW(DW), .SZW(SZW)) u_agu (
    .mode    (req_mode),
    .base    (rf_a_data),
    .idx     (rf_b_data),
    .konst   (req_const),
    .esz     (req_esz),
    .kind    (kind),
    .addr    (ea),
    .val     (imm_val),
    .upd_en  (wb_en),
    .upd_val (wb_val)
  );

  oau_seq #(.DW(DW), .RW(RW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .kind_in    (kind),
    .val_in     (imm_val),
    .upd_en_in  (wb_en),
    .upd_reg_in (req_ra),
    .upd_val_in (wb_val),
    .mem_rdata  (mem_rdata),
    .ptr_phase  (ptr_phase),
    .ready      (req_ready),
    .op_valid   (op_valid),
    .op_data    (op_data),
    .ill        (ill_mode),
    .upd_en     (upd_en),
    .upd_reg    (upd_reg),
    .upd_val    (upd_val)
  );

  // Memory port: second read of a pointer chase has the port; no request is
  // taken in that cycle, so the two sources never collide.
  assign mem_en   = ptr_phase || (take && (kind == K_MEM || kind == K_PTR));
  assign mem_addr = ptr_phase ? mem_rdata : ea;

  // R1: value modes never touch memory
  a_r1_no_mem_for_value: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (req_mode == 4'd0 || req_mode == 4'd1)) |-> !mem_en);
  // R10: illegal codes never touch memory
  a_r10_no_mem_for_ill: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode > 4'd9) |-> !mem_en);
  // R6: the pointer chase issues its second read the cycle after the first
  a_r6_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 4'd6) |=> (mem_en && !req_ready));
endmodule

// File: tb/tb_opnd_addr_unit.sv
`timescale 1ns/1ps
module tb_opnd_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [3:0]  req_ra = '0, req_rb = '0;
  logic [31:0] req_const = '0;
  logic [1:0]  req_esz = '0;
  logic [3:0]  rf_a_addr, rf_b_addr;
  logic [31:0] rf_a_data, rf_b_data;
  logic        mem_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        op_valid, ill_mode, upd_en;
  logic [31:0] op_data, upd_val;
  logic [3:0]  upd_reg;

  int total = 0, bad = 0, cyc = 0, mem_reads = 0;

  typedef struct {
    bit          ill;
    logic [31:0] data;
    bit          ue;
    logic [3:0]  ur;
    logic [31:0] uv;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  opnd_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_ra(req_ra), .req_rb(req_rb), .req_const(req_const),
    .req_esz(req_esz), .rf_a_addr(rf_a_addr), .rf_a_data(rf_a_data),
    .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data), .mem_en(mem_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .op_valid(op_valid),
    .op_data(op_data), .ill_mode(ill_mode), .upd_en(upd_en), .upd_reg(upd_reg),
    .upd_val(upd_val)
  );

  // Register file contents; register 15 sits near the top of the address space
  function automatic logic [31:0] regf(input logic [3:0] n);
    return (n == 4'd15) ? 32'hFFFF_FFF8 : (32'h100 * n + 32'h40);
  endfunction
  // Memory contents as a function of the address
  function automatic logic [31:0] memf(input logic [31:0] a);
    return (~a) ^ (a << 7) ^ 32'h3C00_0001;
  endfunction

  assign rf_a_data = regf(rf_a_addr);
  assign rf_b_data = regf(rf_b_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      mem_rdata <= memf(mem_addr);
      mem_reads <= mem_reads + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [3:0] m, input logic [3:0] a, input logic [3:0] b,
                                 input logic [31:0] k, input logic [1:0] e, input string tag);
    exp_t x;
    logic [31:0] ra, rb, d, t;
    ra = regf(a); rb = regf(b); d = 32'd1 << e;
    x.ill = 0; x.data = '0; x.ue = 0; x.ur = a; x.uv = '0; x.tag = tag; x.due = 0;
    case (m)
      4'd0: x.data = ra;
      4'd1: x.data = k;
      4'd2: x.data = memf(ra + k);
      4'd3: x.data = memf(ra);
      4'd4: x.data = memf(ra + rb);
      4'd5: x.data = memf(k);
      4'd6: x.data = memf(memf(ra));
      4'd7: begin x.data = memf(ra); x.ue = 1; x.uv = ra + d; end
      4'd8: begin t = ra - d; x.data = memf(t); x.ue = 1; x.uv = t; end
      4'd9: x.data = memf(k + ra + rb * d);
      default: x.ill = 1;
    endcase
    return x;
  endfunction

  // Driver: called at a negedge, leaves at the next negedge
  task automatic send(input logic [3:0] m, input logic [3:0] a, input logic [3:0] b,
                      input logic [31:0] k, input logic [1:0] e, input string tag);
    exp_t x;
    req_valid = 1; req_mode = m; req_ra = a; req_rb = b; req_const = k; req_esz = e;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    x = model(m, a, b, k, e, tag);
    x.due = cyc + ((m == 4'd6) ? 2 : 1);
    q.push_back(x);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (op_valid || ill_mode)) begin
      if (q.size() == 0) begin
        check(0, "R11 unexpected output", {31'd0, op_valid}, 32'd0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check(cyc == x.due, {x.tag, " latency"}, cyc, x.due);
        check(ill_mode == x.ill && op_valid == !x.ill, {x.tag, " kind"}, {30'd0, ill_mode, op_valid}, {30'd0, x.ill, !x.ill});
        if (!x.ill) check(op_data == x.data, {x.tag, " data"}, op_data, x.data);
        check(upd_en == x.ue, {x.tag, " upd_en R12"}, {31'd0, upd_en}, {31'd0, x.ue});
        if (x.ue) begin
          check(upd_reg == x.ur, {x.tag, " upd_reg"}, {28'd0, upd_reg}, {28'd0, x.ur});
          check(upd_val == x.uv, {x.tag, " upd_val"}, upd_val, x.uv);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m0;
    repeat (3) @(negedge clk);
    check(op_valid == 0 && ill_mode == 0 && upd_en == 0 && mem_en == 0, "reset outputs",
          {28'd0, op_valid, ill_mode, upd_en, mem_en}, 32'd0);
    check(req_ready == 1, "reset ready R11", {31'd0, req_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);

    // R1, R2, R10: no memory traffic from value and illegal modes
    m0 = mem_reads;
    send(4'd0, 4'd3, 4'd0, 32'h0, 2'd0, "R1 register");
    send(4'd1, 4'd0, 4'd0, 32'hDEAD_BEEF, 2'd0, "R2 immediate");
    send(4'd10, 4'd2, 4'd0, 32'h0, 2'd0, "R10 illegal 10");
    send(4'd15, 4'd2, 4'd0, 32'h0, 2'd0, "R10 illegal 15");
    @(negedge clk);
    check(mem_reads == m0, "R1 R10 no memory read", mem_reads, m0);

    // R11: back-to-back memory modes
    send(4'd2, 4'd5, 4'd0, 32'h20, 2'd0, "R3 displacement");
    send(4'd3, 4'd7, 4'd0, 32'h0, 2'd0, "R3 register-indirect");
    send(4'd4, 4'd2, 4'd9, 32'h0, 2'd0, "R4 indexed");
    send(4'd5, 4'd0, 4'd0, 32'h1234, 2'd0, "R5 absolute");

    // R6: pointer chase and busy cycle
    send(4'd6, 4'd4, 4'd0, 32'h0, 2'd0, "R6 memory-indirect");
    check(req_ready == 0, "R6 ready low in pointer cycle", {31'd0, req_ready}, 32'd0);
    send(4'd0, 4'd1, 4'd0, 32'h0, 2'd0, "R6 follow-up after busy");

    // R7, R8
    send(4'd7, 4'd6, 4'd0, 32'h0, 2'd2, "R7 post-increment");
    send(4'd8, 4'd6, 4'd0, 32'h0, 2'd3, "R8 pre-decrement");
    send(4'd8, 4'd3, 4'd0, 32'h0, 2'd0, "R8 pre-decrement d1");

    // R9: all four element sizes
    for (int e = 0; e < 4; e++)
      send(4'd9, 4'd2, 4'd3, 32'h100, e[1:0], "R9 scaled");

    // R13: wrap past 2^32
    send(4'd7, 4'd15, 4'd0, 32'h0, 2'd3, "R13 post-increment wrap");
    send(4'd2, 4'd15, 4'd0, 32'h10, 2'd0, "R13 displacement wrap");
    send(4'd9, 4'd15, 4'd15, 32'h0, 2'd1, "R13 scaled wrap");
    send(4'd6, 4'd5, 4'd0, 32'h0, 2'd0, "R6 second chase");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11 all results returned", q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule